// File: doc/BRIEF.md
# LCD pixel format unpacker

This block sits between the frame-buffer fetch path and the colour pipeline of a display controller. It takes one 32-bit frame-buffer word at a time over a valid/ready handshake. It splits the word into the pixels it holds and hands them downstream one per cycle over a second valid/ready handshake. Pixels of 8 bits per pixel or fewer come out as a palette index with a strobe. Deeper pixels come out as 24-bit RGB with 8 bits per channel.

The pixel depth, the channel order, the position of pixels inside a word and the 16-bit layout all come from static control inputs. These are captured together with each word. A variant select picks between a basic decoder and an extended one. In the basic decoder, the 16-bit layout is chosen by a 2-bit external mux input. In the extended decoder, extra depth codes select it directly. The block also reports how many bytes one display line occupies for the current column count and depth, so the fetch side can size its requests.

Top module: `lcd_pix_unpack`

## Requirements
- R1: While reset is asserted and after its release, `pix_valid` is 0 and `word_ready` is 1.
- R2: A word is taken when `word_valid` and `word_ready` are both high. It yields 32/bpp pixels, and each pixel is consumed in a cycle where `pix_ready` is high. While `pix_valid` is high and `pix_ready` is low, all pixel outputs hold. `word_ready` is high only when no pixel is pending, or when the last pixel of the held word is consumed in that cycle, so words follow each other with no gap.
- R3: `depth` codes are 0=1, 1=2, 2=4, 3=8, 4=16 and 5=32 bits per pixel. For codes 0 to 3, `pix_index` carries the pixel zero-extended, `pix_idx_stb` is high and `pix_rgb` is 0. In the RGB modes, `pix_index` is 0 and the strobe is low.
- R4: With `be_byte` and `be_pix` both 0, pixel k of a word is taken from the bits starting at bit k*bpp.
- R5: With `be_byte`=1, pixel k is taken from the bits ending at bit 31-k*bpp, whatever `be_pix` is.
- R6: With only `be_pix`=1, bytes are taken lowest first. Inside each byte, pixels narrower than 8 bits are taken from the most significant end. The setting has no effect at 8 bpp and above.
- R7: In 32 bpp mode, bits [7:0] form the low channel, [15:8] green and [23:16] the high channel, and [31:24] are dropped. In every RGB format, `bgr`=1 makes the low channel red and the high channel blue, and `bgr`=0 swaps the two.
- R8: On the basic variant (`ext_mode`=0) at depth 4, `mux_sel`=1 decodes 5551: fields [4:0], [9:5] and [14:10], with bit 15 dropped. A field narrower than 8 bits is shifted to the top of its channel and the low bits are filled with 0.
- R9: On the basic variant at depth 4, `mux_sel`=3 decodes 565: red from [4:0], green from [10:5] and blue from [15:11], with `bgr` ignored.
- R10: On the basic variant at depth 4, `mux_sel` 0 and 2 decode 565 and honour `bgr`. On this variant, depth codes 6 and 7 act as code 4.
- R11: With `ext_mode`=1, `mux_sel` is ignored. Depth 4 is 5551, depth 6 is 565, and depth 7 is 12-bit 444 taken from bits [11:0] of each 16-bit slot. All three honour `bgr`.
- R12: The control inputs are captured when a word is taken. Changing them afterwards does not affect the pixels of that word.
- R13: `line_bytes` equals `cols` divided by 8, 4 or 2 for depth 0, 1 or 2. It equals `cols` for depth 3, twice `cols` for the 16-bit and 12-bit modes, and four times `cols` for depth 5. It follows its inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Frame-buffer word offered |
| word_ready | output | 1 | Block takes the offered word |
| word_data | input | 32 | Frame-buffer word |
| depth | input | 3 | Pixel depth code |
| ext_mode | input | 1 | 1 selects the extended decoder |
| mux_sel | input | 2 | External 16-bit layout select (basic variant) |
| bgr | input | 1 | Channel order select |
| be_byte | input | 1 | Whole-word big-endian pixel order |
| be_pix | input | 1 | Big-endian pixel order inside each byte |
| cols | input | COL_W | Pixels per display line |
| line_bytes | output | COL_W+2 | Bytes per display line |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Downstream takes the pixel |
| pix_rgb | output | 24 | Red [23:16], green [15:8], blue [7:0] |
| pix_index | output | 8 | Palette index |
| pix_idx_stb | output | 1 | Pixel is a palette index |

## Verification
The hardest situation to reach is the cycle where the last pixel of one word leaves under a stalled-then-released sink while the next word waits at the input. Only there do `word_ready` and pixel consumption have to coincide. The bench first holds `pix_ready` low with a second word already offered, then releases it and checks that the new word's first pixel appears on the very next cycle. A second hard case is a control change in the middle of a word. The bench switches the depth right after a word is taken and checks that the remaining pixels keep the old width and count.

// File: rtl/lcdu_pkg.sv
package lcdu_pkg;
    localparam int WORD_W  = 32;
    localparam int CH_W    = 8;
    localparam int SLOT_W  = $clog2(WORD_W);
    localparam int LOG_CNT = $clog2(WORD_W) + 1;

    typedef enum logic [2:0] {
        FMT_IDX  = 3'd0,
        FMT_5551 = 3'd1,
        FMT_565  = 3'd2,
        FMT_444  = 3'd3,
        FMT_888  = 3'd4
    } fmt_e;

    typedef enum logic [1:0] {
        ORD_LE      = 2'd0,
        ORD_BE_WORD = 2'd1,
        ORD_BE_SUB  = 2'd2
    } ord_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [2:0] bpp_log;
        logic       red_low;
        ord_e       ord;
    } mode_t;
endpackage

// File: rtl/lcdu_mode_dec.sv
module lcdu_mode_dec
    import lcdu_pkg::*;
(
    input  logic [2:0] depth,
    input  logic       ext_mode,
    input  logic [1:0] mux_sel,
    input  logic       bgr,
    input  logic       be_byte,
    input  logic       be_pix,
    output mode_t      mode
);
    logic [2:0] eff_depth;

    always_comb begin
        // R10: basic variant folds codes 6 and 7 onto the 16-bit code
        eff_depth = (!ext_mode && depth[2:1] == 2'b11) ? 3'd4 : depth;

        mode.red_low = bgr;
        mode.ord     = be_byte ? ORD_BE_WORD : (be_pix ? ORD_BE_SUB : ORD_LE);
        mode.fmt     = FMT_IDX;
        mode.bpp_log = eff_depth;

        case (eff_depth)
            3'd4: begin
                if (ext_mode) begin
                    mode.fmt = FMT_5551;                       // R11
                end else begin
                    case (mux_sel)
                        2'd1: mode.fmt = FMT_5551;             // R8
                        2'd3: begin
                            mode.fmt     = FMT_565;            // R9
                            mode.red_low = 1'b1;
                        end
                        default: mode.fmt = FMT_565;           // R10
                    endcase
                end
            end
            3'd5: begin
                mode.fmt     = FMT_888;
                mode.bpp_log = 3'd5;
            end
            3'd6: begin
                mode.fmt     = FMT_565;
                mode.bpp_log = 3'd4;
            end
            3'd7: begin
                mode.fmt     = FMT_444;
                mode.bpp_log = 3'd4;
            end
            default: begin
                mode.fmt     = FMT_IDX;
                mode.bpp_log = eff_depth;
            end
        endcase
    end
endmodule

// File: rtl/lcdu_slot_sel.sv
module lcdu_slot_sel
    import lcdu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [SLOT_W-1:0] slot,
    input  logic [2:0]        bpp_log,
    input  ord_e              ord,
    output logic [WORD_W-1:0] field
);
    localparam int POS_W = SLOT_W + 1;

    logic [WORD_W-1:0] cand [LOG_CNT];

    for (genvar g = 0; g < LOG_CNT; g++) begin : g_width
        localparam int BW = 1 << g;
        localparam logic [WORD_W-1:0] MASK =
            (BW >= WORD_W) ? {WORD_W{1'b1}} : ((WORD_W'(1) << BW) - WORD_W'(1));

        logic [POS_W-1:0] lo;
        logic [POS_W-1:0] pos;

        assign lo = POS_W'({1'b0, slot} << g);

        if (BW < CH_W) begin : g_sub
            always_comb begin
                case (ord)
                    ORD_BE_WORD: pos = POS_W'(WORD_W - BW) - lo;               // R5
                    ORD_BE_SUB:  pos = {lo[POS_W-1:3], 3'b000}
                                       + POS_W'(CH_W - BW)
                                       - {{(POS_W-3){1'b0}}, lo[2:0]};        // R6
                    default:     pos = lo;                                    // R4
                endcase
            end
        end else begin : g_full
            always_comb begin
                if (ord == ORD_BE_WORD) pos = POS_W'(WORD_W - BW) - lo;        // R5
                else                    pos = lo;
            end
        end

        assign cand[g] = (word >> pos) & MASK;
    end

    always_comb begin
        field = '0;
        for (int i = 0; i < LOG_CNT; i++) begin
            if (32'(bpp_log) == i) field = cand[i];
        end
    end
endmodule

// File: rtl/lcdu_chan_expand.sv
module lcdu_chan_expand
    import lcdu_pkg::*;
(
    input  logic [WORD_W-1:0] field,
    input  fmt_e              fmt,
    input  logic              red_low,
    output logic [3*CH_W-1:0] rgb,
    output logic [CH_W-1:0]   index,
    output logic              is_index
);
    logic [CH_W-1:0] c_lo, c_mid, c_hi;

    always_comb begin
        c_lo     = '0;
        c_mid    = '0;
        c_hi     = '0;
        is_index = 1'b0;
        index    = '0;
        case (fmt)
            FMT_5551: begin                                   // R8
                c_lo  = {field[4:0],   3'b000};
                c_mid = {field[9:5],   3'b000};
                c_hi  = {field[14:10], 3'b000};
            end
            FMT_565: begin
                c_lo  = {field[4:0],   3'b000};
                c_mid = {field[10:5],  2'b00};
                c_hi  = {field[15:11], 3'b000};
            end
            FMT_444: begin                                    // R11
                c_lo  = {field[3:0],  4'b0000};
                c_mid = {field[7:4],  4'b0000};
                c_hi  = {field[11:8], 4'b0000};
            end
            FMT_888: begin                                    // R7
                c_lo  = field[7:0];
                c_mid = field[15:8];
                c_hi  = field[23:16];
            end
            default: begin                                    // R3
                is_index = 1'b1;
                index    = field[CH_W-1:0];
            end
        endcase
        rgb = red_low ? {c_lo, c_mid, c_hi} : {c_hi, c_mid, c_lo};
    end
endmodule

// File: rtl/lcdu_line_len.sv
module lcdu_line_len #(
    parameter int COL_W = 12
) (
    input  logic [COL_W-1:0] cols,
    input  logic [2:0]       bpp_log,
    output logic [COL_W+1:0] bytes
);
    logic [COL_W+1:0] wide;

    assign wide = {2'b00, cols};

    always_comb begin
        case (bpp_log)                                        // R13
            3'd0:    bytes = wide >> 3;
            3'd1:    bytes = wide >> 2;
            3'd2:    bytes = wide >> 1;
            3'd3:    bytes = wide;
            3'd4:    bytes = wide << 1;
            default: bytes = wide << 2;
        endcase
    end
endmodule

// File: rtl/lcd_pix_unpack.sv
module lcd_pix_unpack
    import lcdu_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_valid,
    output logic                word_ready,
    input  logic [WORD_W-1:0]   word_data,
    input  logic [2:0]          depth,
    input  logic                ext_mode,
    input  logic [1:0]          mux_sel,
    input  logic                bgr,
    input  logic                be_byte,
    input  logic                be_pix,
    input  logic [COL_W-1:0]    cols,
    output logic [COL_W+1:0]    line_bytes,
    output logic                pix_valid,
    input  logic                pix_ready,
    output logic [3*CH_W-1:0]   pix_rgb,
    output logic [CH_W-1:0]     pix_index,
    output logic                pix_idx_stb
);
    localparam int LB_W = COL_W + 2;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        mode_t             mode;
        logic              busy;
        logic [SLOT_W-1:0] slot;
        logic [LB_W-1:0]   lbytes;
    } state_t;

    state_t st_d, st_q;

    mode_t             live_mode;
    logic [LB_W-1:0]   live_bytes;
    logic [WORD_W-1:0] field;
    logic [SLOT_W:0]   ppw;
    logic              last_slot;
    logic              fire;
    logic              take;
    logic              is_idx;

    lcdu_mode_dec u_dec (
        .depth    (depth),
        .ext_mode (ext_mode),
        .mux_sel  (mux_sel),
        .bgr      (bgr),
        .be_byte  (be_byte),
        .be_pix   (be_pix),
        .mode     (live_mode)
    );

    lcdu_line_len #(.COL_W(COL_W)) u_len (
        .cols    (cols),
        .bpp_log (live_mode.bpp_log),
        .bytes   (live_bytes)
    );

    lcdu_slot_sel u_sel (
        .word    (st_q.word),
        .slot    (st_q.slot),
        .bpp_log (st_q.mode.bpp_log),
        .ord     (st_q.mode.ord),
        .field   (field)
    );

    lcdu_chan_expand u_exp (
        .field    (field),
        .fmt      (st_q.mode.fmt),
        .red_low  (st_q.mode.red_low),
        .rgb      (pix_rgb),
        .index    (pix_index),
        .is_index (is_idx)
    );

    assign ppw        = (SLOT_W + 1)'(WORD_W) >> st_q.mode.bpp_log;
    assign last_slot  = ({1'b0, st_q.slot} == ppw - 1'b1);
    assign fire       = st_q.busy && pix_ready;
    assign word_ready = !st_q.busy || (fire && last_slot);     // R2
    assign take       = word_valid && word_ready;

    assign pix_valid   = st_q.busy;
    assign pix_idx_stb = st_q.busy && is_idx;
    assign line_bytes  = st_q.lbytes;

    always_comb begin
        st_d        = st_q;
        st_d.lbytes = live_bytes;                              // R13
        if (take) begin                                        // R12
            st_d.word = word_data;
            st_d.mode = live_mode;
            st_d.busy = 1'b1;
            st_d.slot = '0;
        end else if (fire) begin
            if (last_slot) st_d.busy = 1'b0;
            else           st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;                                // R1
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lcdu_checker.sv
module lcdu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        word_valid,
    input logic        word_ready,
    input logic        pix_valid,
    input logic        pix_ready,
    input logic [23:0] pix_rgb,
    input logic [7:0]  pix_index,
    input logic        pix_idx_stb
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (!pix_valid && word_ready)); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_rgb)
            && $stable(pix_index) && $stable(pix_idx_stb))); // R2

    AST_READY_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> (!pix_valid || pix_ready)); // R2

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> word_ready); // R2

    AST_TAKE_GIVES_PIX: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready) |=> pix_valid); // R2

    AST_STB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pix_idx_stb |-> pix_valid); // R3

    AST_IDX_NO_RGB: assert property (@(posedge clk) disable iff (!rst_n)
        pix_idx_stb |-> (pix_rgb == 24'h0)); // R3

    AST_RGB_NO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_idx_stb) |-> (pix_index == 8'h0)); // R3
endmodule

bind lcd_pix_unpack lcdu_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_valid  (word_valid),
    .word_ready  (word_ready),
    .pix_valid   (pix_valid),
    .pix_ready   (pix_ready),
    .pix_rgb     (pix_rgb),
    .pix_index   (pix_index),
    .pix_idx_stb (pix_idx_stb)
);

// File: tb/lcd_pix_unpack_bench.sv
module lcd_pix_unpack_bench;
    localparam int COL_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              word_valid = 1'b0;
    logic              word_ready;
    logic [31:0]       word_data = '0;
    logic [2:0]        depth = '0;
    logic              ext_mode = 1'b0;
    logic [1:0]        mux_sel = '0;
    logic              bgr = 1'b0;
    logic              be_byte = 1'b0;
    logic              be_pix = 1'b0;
    logic [COL_W-1:0]  cols = '0;
    logic [COL_W+1:0]  line_bytes;
    logic              pix_valid;
    logic              pix_ready = 1'b0;
    logic [23:0]       pix_rgb;
    logic [7:0]        pix_index;
    logic              pix_idx_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    lcd_pix_unpack #(.COL_W(COL_W)) u_lcd_pix_unpack (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
        .word_data(word_data), .depth(depth), .ext_mode(ext_mode), .mux_sel(mux_sel),
        .bgr(bgr), .be_byte(be_byte), .be_pix(be_pix), .cols(cols),
        .line_bytes(line_bytes), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_rgb(pix_rgb), .pix_index(pix_index), .pix_idx_stb(pix_idx_stb)
    );

    typedef struct packed {
        logic [2:0]  dep;
        logic        ext;
        logic [1:0]  mux;
        logic        bgr;
        logic        beb;
        logic        bep;
        logic [31:0] word;
        logic [4:0]  k;
        logic        isidx;
        logic [23:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0004, 5'd2, 1'b1, 24'h000001, 4'd3},  // R3 1 bpp
        '{3'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_00C4, 5'd3, 1'b1, 24'h000003, 4'd4},  // R4 2 bpp
        '{3'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 5'd1, 1'b1, 24'h000007, 4'd4},  // R4 4 bpp
        '{3'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 5'd2, 1'b1, 24'h000034, 4'd3},  // R3 8 bpp
        '{3'd3, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 32'h1234_5678, 5'd0, 1'b1, 24'h000012, 4'd5},  // R5 priority
        '{3'd2, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 32'h1234_5678, 5'd1, 1'b1, 24'h000002, 4'd5},  // R5 4 bpp
        '{3'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h1234_5678, 5'd0, 1'b1, 24'h000007, 4'd6},  // R6 nibble
        '{3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0000_0080, 5'd0, 1'b1, 24'h000001, 4'd6},  // R6 1 bpp
        '{3'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h1234_5678, 5'd0, 1'b1, 24'h000078, 4'd6},  // R6 no effect
        '{3'd5, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 32'hAA33_2211, 5'd0, 1'b0, 24'h112233, 4'd7},  // R7 bgr 1
        '{3'd5, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'hAA33_2211, 5'd0, 1'b0, 24'h332211, 4'd7},  // R7 bgr 0
        '{3'd4, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_801F, 5'd0, 1'b0, 24'hF80000, 4'd8},  // R8 top bit dropped
        '{3'd4, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 32'h03E0_0000, 5'd1, 1'b0, 24'h00F800, 4'd8},  // R8 green
        '{3'd4, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0000_F800, 5'd0, 1'b0, 24'h0000F8, 4'd9},  // R9 bgr 0
        '{3'd4, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0000_F800, 5'd0, 1'b0, 24'h0000F8, 4'd9},  // R9 bgr 1
        '{3'd4, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_F800, 5'd0, 1'b0, 24'hF80000, 4'd10}, // R10 mux 0
        '{3'd4, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0000_07E0, 5'd0, 1'b0, 24'h00FC00, 4'd10}, // R10 green 6 bit
        '{3'd6, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 32'h0000_001F, 5'd0, 1'b0, 24'hF80000, 4'd10}, // R10 code 6 folds
        '{3'd4, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 32'h0000_7C00, 5'd0, 1'b0, 24'hF80000, 4'd11}, // R11 mux ignored
        '{3'd6, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0000_F800, 5'd0, 1'b0, 24'h0000F8, 4'd11}, // R11 565
        '{3'd7, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 32'hFABC_0000, 5'd1, 1'b0, 24'hC0B0A0, 4'd11}, // R11 444
        '{3'd4, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 32'h001F_0000, 5'd0, 1'b0, 24'hF80000, 4'd5}   // R5 16 bpp
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int ppw_of(input logic [2:0] d, input logic ext);
        if (d <= 3'd3) return 32 >> d;
        if (d == 3'd5) return 1;
        return 2;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pix_valid in reset", 32'(pix_valid), 32'd0);
        check("R1 word_ready in reset", 32'(word_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pix_valid after reset", 32'(pix_valid), 32'd0);
        check("R1 word_ready after reset", 32'(word_ready), 32'd1);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            int ppw;
            string tag;
            tag = $sformatf("R%0d vec %0d", VECS[v].req, v);
            ppw = ppw_of(VECS[v].dep, VECS[v].ext);
            depth = VECS[v].dep; ext_mode = VECS[v].ext; mux_sel = VECS[v].mux;
            bgr = VECS[v].bgr; be_byte = VECS[v].beb; be_pix = VECS[v].bep;
            word_data = VECS[v].word; word_valid = 1'b1; pix_ready = 1'b1;
            @(negedge clk);
            word_valid = 1'b0;
            for (int n = 0; n < ppw; n++) begin
                if (!pix_valid) begin
                    check({tag, " valid"}, 32'(pix_valid), 32'd1);
                end
                if (n == int'(VECS[v].k)) begin
                    check({tag, " strobe"}, 32'(pix_idx_stb), 32'(VECS[v].isidx));
                    if (VECS[v].isidx) check({tag, " index"}, 32'(pix_index), 32'(VECS[v].val));
                    else               check({tag, " rgb"}, 32'(pix_rgb), 32'(VECS[v].val));
                end
                @(negedge clk);
            end
            check({tag, " R2 drained"}, 32'(pix_valid), 32'd0);
        end

        // R2: stall hold and back-to-back words
        depth = 3'd3; ext_mode = 1'b0; be_byte = 1'b0; be_pix = 1'b0;
        word_data = 32'h1234_5678; word_valid = 1'b1; pix_ready = 1'b0;
        @(negedge clk);
        word_data = 32'hA1B2_C3D4;
        for (int s = 0; s < 3; s++) begin
            check("R2 stalled pixel", 32'(pix_index), 32'h78);
            check("R2 stalled valid", 32'(pix_valid), 32'd1);
            check("R2 no take while busy", 32'(word_ready), 32'd0);
            if (s < 2) @(negedge clk);
        end
        pix_ready = 1'b1;
        @(negedge clk);
        check("R2 second pixel", 32'(pix_index), 32'h56);
        @(negedge clk);
        check("R2 third pixel", 32'(pix_index), 32'h34);
        @(negedge clk);
        check("R2 last pixel", 32'(pix_index), 32'h12);
        check("R2 ready on last", 32'(word_ready), 32'd1);
        @(negedge clk);
        word_valid = 1'b0;
        check("R2 next word no gap", 32'(pix_valid), 32'd1);
        check("R2 next word pixel", 32'(pix_index), 32'hD4);
        repeat (3) @(negedge clk);
        check("R2 next word last", 32'(pix_index), 32'hA1);
        @(negedge clk);
        check("R2 idle after drain", 32'(pix_valid), 32'd0);

        // R12: controls changed mid-word do not affect that word
        depth = 3'd3; word_data = 32'h1234_5678; word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0; depth = 3'd0; be_byte = 1'b1;
        check("R12 first", 32'(pix_index), 32'h78);
        @(negedge clk);
        check("R12 second keeps width", 32'(pix_index), 32'h56);
        @(negedge clk);
        check("R12 third keeps order", 32'(pix_index), 32'h34);
        @(negedge clk);
        check("R12 fourth", 32'(pix_index), 32'h12);
        @(negedge clk);
        check("R12 keeps count", 32'(pix_valid), 32'd0);
        be_byte = 1'b0;

        // R13: line length
        cols = 12'd640; depth = 3'd0; ext_mode = 1'b0;
        @(negedge clk);
        check("R13 1 bpp", 32'(line_bytes), 32'd80);
        depth = 3'd2;
        @(negedge clk);
        check("R13 4 bpp", 32'(line_bytes), 32'd320);
        depth = 3'd3;
        @(negedge clk);
        check("R13 8 bpp", 32'(line_bytes), 32'd640);
        depth = 3'd5;
        @(negedge clk);
        check("R13 32 bpp", 32'(line_bytes), 32'd2560);
        depth = 3'd7; ext_mode = 1'b1;
        @(negedge clk);
        check("R13 12 bpp", 32'(line_bytes), 32'd1280);
        cols = 12'd4095; depth = 3'd1; ext_mode = 1'b0;
        @(negedge clk);
        check("R13 2 bpp max cols", 32'(line_bytes), 32'd1023);

        finish_run();
    end
endmodule